// File: doc/BRIEF.md
# Banked Register and Stack Address Unit

This unit turns the core's register-operand and stack requests into byte addresses for the on-chip working RAM. A register operand names one of eight working registers. A two-bit bank field then moves that operand into one of four eight-byte windows at the bottom of RAM. The same unit holds the stack pointer. A push first moves the pointer up by one and then writes at the new top. A pop reads the current top and then moves the pointer down by one. The core can also load the pointer directly.

Each cycle the unit presents one RAM address on its output. It also shows the pointer value and raises a flag when a push reaches past the top of general RAM. The RAM array and the instruction decode sit outside the unit. The pointer is a plain 8-bit register that wraps around. It is never clamped to the RAM size, so the flag is the only warning of a runaway stack.

Top module: `bank_stack_agu`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released, the stack pointer reads 0x07 and `stackOvf` is low.
- R2: With no push, pop or pointer load, `ramAddr` equals `bankSel`*8 + `regNum`, so addresses 0x00 to 0x1F cover banks 0 to 3 with registers 0 to 7.
- R3: A push (`pushReq` high) puts `ramAddr` = pointer + 1 in the same cycle, and the pointer takes that value at the next clock edge. The first push after reset therefore writes at 0x08.
- R4: A pop (`popReq` high) puts `ramAddr` = pointer in the same cycle, and the pointer drops by one at the next clock edge. Data pushed is read back in last-in, first-out order.
- R5: A pointer load (`spWrEn` high) copies `spWrData` into the pointer at the next edge. In that cycle any push or pop is ignored, `ramAddr` shows the register address, and `stackOvf` stays low.
- R6: When push and pop are requested together without a load, the push is performed and the pop is ignored.
- R7: The pointer wraps modulo 256. A push at 0xFF addresses 0x00, and a pop at 0x00 leaves 0xFF.
- R8: `stackOvf` is high exactly in a cycle where a push is performed and its target address is above 0x7F.
- R9: With no push, pop or load, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regNum | input | 3 | Working-register number 0 to 7 |
| bankSel | input | 2 | Register bank select 0 to 3 |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| spWrEn | input | 1 | Direct pointer load strobe |
| spWrData | input | 8 | Value for a pointer load |
| ramAddr | output | 8 | Internal RAM byte address for this cycle |
| spOut | output | 8 | Current stack pointer |
| stackOvf | output | 1 | Push target above general RAM |

## Verification
The bench goes after the pre-increment. A design that writes before it increments would place the first push at 0x07 and overwrite register 7 of bank 0. Pushing the whole 256-byte space and then popping it back checks the wrap at 0xFF/0x00 and the last-in, first-out order. A post-decrement or an off-by-one pop would return the wrong byte. Loads that come together with push or pop strobes show whether the load really wins, which a wrong priority order would break. The flag is probed at pointers 0x7E and 0x7F, where a wrong compare would fire one slot early or one slot late.

// File: rtl/agu_pkg.sv
package agu_pkg;
  // strobes from the control decode to the datapath, at most one high
  typedef struct packed {
    logic doLoad;
    logic doPush;
    logic doPop;
  } agu_strobe_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushReq,
  input  logic        popReq,
  input  logic        spWrEn,
  output agu_strobe_t strobes
);
  // priority: load, then push, then pop
  always_comb begin
    strobes = '0;
    if (spWrEn)       strobes.doLoad = 1'b1;
    else if (pushReq) strobes.doPush = 1'b1;
    else if (popReq)  strobes.doPop  = 1'b1;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doLoad, strobes.doPush, strobes.doPop})); // R5
  AST_LOAD_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> !strobes.doPush && !strobes.doPop); // R5
  AST_PUSH_OVER_POP: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !spWrEn) |-> !strobes.doPop); // R6
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 3,
  parameter int BANK_W   = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  agu_strobe_t       strobes,
  input  logic [REG_W-1:0]  regNum,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] spWrData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [ADDR_W-1:0] spOut,
  output logic              stackOvf
);
  localparam int BANK_SPAN = 1 << REG_W;

  logic [ADDR_W-1:0] spReg;
  logic [ADDR_W-1:0] spInc;
  logic [ADDR_W-1:0] spDec;
  logic [ADDR_W-1:0] regAddr;

  assign spInc   = spReg + ADDR_W'(1);
  assign spDec   = spReg - ADDR_W'(1);
  assign regAddr = ADDR_W'(bankSel) * ADDR_W'(BANK_SPAN) + ADDR_W'(regNum);

  always_ff @(posedge clk) begin
    if (!rstN)                spReg <= SP_RESET;
    else if (strobes.doLoad)  spReg <= spWrData;
    else if (strobes.doPush)  spReg <= spInc;
    else if (strobes.doPop)   spReg <= spDec;
  end

  always_comb begin
    if (strobes.doPush)     ramAddr = spInc;
    else if (strobes.doPop) ramAddr = spReg;
    else                    ramAddr = regAddr;
  end

  assign spOut    = spReg;
  assign stackOvf = strobes.doPush && (spInc > RAM_TOP);

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobes.doPush) |=> spReg == $past(spReg) + ADDR_W'(1)); // R3
  AST_PUSH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobes.doPush) |=> spReg == $past(ramAddr)); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobes.doPop) |=> spReg == $past(spReg) - ADDR_W'(1)); // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobes.doLoad) |=> spReg == $past(spWrData)); // R5
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !strobes.doLoad && !strobes.doPush && !strobes.doPop) |=> $stable(spReg)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doPush |-> !stackOvf); // R8
endmodule

// File: rtl/bank_stack_agu.sv
module bank_stack_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 3,
  parameter int BANK_W   = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  regNum,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              spWrEn,
  input  logic [ADDR_W-1:0] spWrData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [ADDR_W-1:0] spOut,
  output logic              stackOvf
);
  agu_strobe_t strobes;

  agu_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pushReq (pushReq),
    .popReq  (popReq),
    .spWrEn  (spWrEn),
    .strobes (strobes)
  );

  agu_datapath #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .BANK_W   (BANK_W),
    .SP_RESET (SP_RESET),
    .RAM_TOP  (RAM_TOP)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regNum   (regNum),
    .bankSel  (bankSel),
    .spWrData (spWrData),
    .ramAddr  (ramAddr),
    .spOut    (spOut),
    .stackOvf (stackOvf)
  );
endmodule

// File: tb/sim_bank_stack_agu.sv
module sim_bank_stack_agu;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regNum = '0;
  logic [1:0] bankSel = '0;
  logic       pushReq = 1'b0;
  logic       popReq = 1'b0;
  logic       spWrEn = 1'b0;
  logic [7:0] spWrData = '0;
  logic [7:0] ramAddr;
  logic [7:0] spOut;
  logic       stackOvf;

  int checks = 0;
  int failures = 0;
  logic [7:0] mem [256];
  logic [7:0] spM;

  always #4 clk = ~clk;

  bank_stack_agu u0 (
    .clk(clk), .rstN(rstN), .regNum(regNum), .bankSel(bankSel),
    .pushReq(pushReq), .popReq(popReq), .spWrEn(spWrEn), .spWrData(spWrData),
    .ramAddr(ramAddr), .spOut(spOut), .stackOvf(stackOvf)
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // drive one cycle's request after a falling edge, settle briefly
  task automatic drive(logic ps, logic pp, logic ld, logic [7:0] d, logic [1:0] b, logic [2:0] r);
    @(negedge clk);
    pushReq = ps; popReq = pp; spWrEn = ld; spWrData = d; bankSel = b; regNum = r;
    #1;
  endtask

  task automatic clockIn();
    @(posedge clk);
    #1;
    pushReq = 1'b0; popReq = 1'b0; spWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp in reset", spOut, 8'h07);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 sp after reset", spOut, 8'h07);
    chk("R1 ovf after reset", stackOvf, 0);
    spM = 8'h07;

    // register mapping sweep
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 8; r++) begin
        drive(0, 0, 0, 8'h00, 2'(b), 3'(r));
        chk("R2 reg addr", ramAddr, b * 8 + r);
        clockIn();
        chk("R9 sp hold", spOut, spM);
      end
    end

    // push through the full space with wrap
    for (int i = 0; i < 256; i++) begin
      logic [7:0] tgt;
      tgt = spM + 8'd1;
      drive(1, 0, 0, 8'h00, 2'(i % 4), 3'(i % 8));
      if (i == 0) chk("R3 first push at 08", ramAddr, 8'h08);
      else if (spM == 8'hFF) chk("R7 push wraps to 00", ramAddr, 8'h00);
      else chk("R3 push addr", ramAddr, tgt);
      chk("R8 ovf on push", stackOvf, (tgt > 8'h7F) ? 1 : 0);
      mem[ramAddr] = 8'(i) ^ 8'hA5;
      clockIn();
      chk("R3 sp after push", spOut, tgt);
      spM = tgt;
    end

    // pop everything back
    for (int j = 0; j < 256; j++) begin
      logic [7:0] nxt;
      logic [7:0] idx;
      nxt = spM - 8'd1;
      idx = spM - 8'd8;
      drive(0, 1, 0, 8'h00, 2'd3, 3'd7);
      chk("R4 pop addr", ramAddr, spM);
      chk("R4 LIFO data", mem[ramAddr], idx ^ 8'hA5);
      chk("R8 no ovf on pop", stackOvf, 0);
      clockIn();
      if (spM == 8'h00) chk("R7 pop wraps to FF", spOut, 8'hFF);
      else chk("R4 sp after pop", spOut, nxt);
      spM = nxt;
    end

    // load beats push
    drive(1, 0, 1, 8'h40, 2'd2, 3'd5);
    chk("R5 load masks push addr", ramAddr, 8'h15);
    chk("R5 load no ovf", stackOvf, 0);
    clockIn();
    chk("R5 load value", spOut, 8'h40);
    // load beats pop
    drive(0, 1, 1, 8'h7E, 2'd1, 3'd1);
    chk("R5 load masks pop addr", ramAddr, 8'h09);
    clockIn();
    chk("R5 load over pop", spOut, 8'h7E);
    // overflow boundary
    drive(1, 0, 0, 8'h00, 2'd0, 3'd0);
    chk("R8 push to 7F no ovf", stackOvf, 0);
    chk("R3 push addr 7F", ramAddr, 8'h7F);
    clockIn();
    drive(1, 0, 0, 8'h00, 2'd0, 3'd0);
    chk("R8 push to 80 ovf", stackOvf, 1);
    clockIn();
    chk("R3 sp 80", spOut, 8'h80);
    // load beats push even in overflow zone
    drive(1, 0, 1, 8'hF0, 2'd0, 3'd3);
    chk("R5 load hides ovf", stackOvf, 0);
    clockIn();
    chk("R5 load F0", spOut, 8'hF0);
    // push beats pop
    drive(1, 1, 0, 8'h00, 2'd0, 3'd0);
    chk("R6 push wins addr", ramAddr, 8'hF1);
    clockIn();
    chk("R6 push wins sp", spOut, 8'hF1);
    // idle hold
    drive(0, 0, 0, 8'h33, 2'd3, 3'd2);
    chk("R2 reg addr idle", ramAddr, 8'h1A);
    clockIn();
    chk("R9 hold idle", spOut, 8'hF1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule